// File: doc/BRIEF.md
# Adaptive Leaky Integrate-and-Fire Neuron

This block is one hidden-layer spiking neuron that advances by one timestep on each cycle where `step_en` is high. On that step it takes an already summed, signed synaptic current, lets its membrane potential leak, adds the current, and compares the result with a threshold. When the potential reaches the threshold, it emits a spike, lowers the potential by the threshold value, and becomes refractory for a fixed number of timesteps. While refractory, incoming current is discarded. Elaboration can build the neuron either as a plain leaky integrator with a fixed threshold, or as an adaptive neuron. In the adaptive form, every spike raises the threshold, and the extra amount then fades back toward the base value.

All state uses signed 24-bit fixed point in two's complement: bit 23 is the sign, bits 22..16 hold the integer part and bits 15..0 hold the fraction. Leak factors are applied with shifts and subtraction instead of multipliers. A short shift chain carries the spike and the potential to the recurrent fan-out, so that neighbours see them a fixed number of timesteps late.

A small controller sequences the refractory period. It has two states. In `ST_INTEGRATE` the neuron accepts current and may fire. In `ST_REFRACT` current is forced to zero and firing is blocked. The controller makes two transitions: a spike on a step moves it from ST_INTEGRATE to ST_REFRACT, and the last refractory step moves it back to ST_INTEGRATE.

Top module: `alif_neuron`

## Requirements
- R1: A synchronous `rst` clears the potential, the adaptation variable, the refractory controller, the spike output and both delay chains. Out of reset, `v_o`=0, `spike_o`=0, `refr_o`=0 and `thr_o`=VTHR.
- R2: When `step_en` is low, no output or internal state changes.
- R3: On a step that is not refractory, the new potential is sat(sat(v − (v >>> ALPHA_SHIFT) + i_syn)), where >>> is an arithmetic right shift. When no spike occurs, this value is written back.
- R4: A spike occurs when the summed potential is greater than or equal to `thr_o` (signed compare). The stored potential then becomes sat(sum − thr). `spike_o` is high from that step until the next step.
- R5: After a spike, the next REFR_STEPS−1 steps are refractory, and `refr_o` is high during them. On those steps the current is replaced by zero, the leak still applies, and no spike can occur. The earliest following spike is REFR_STEPS steps after the previous one.
- R6: In adaptive mode, the adaptation variable a becomes sat(a − (a >>> RHO_SHIFT) + (spike ? ADAPT_INC : 0)) on each step. `thr_o` = sat(VTHR + (a << BETA_SHL)) and is never below VTHR.
- R7: In plain mode (ADAPTIVE=0), the adaptation variable stays zero and `thr_o` always equals VTHR.
- R8: `spike_dly_o` and `v_dly_o` show the values that `spike_o` and `v_o` had DELAY steps earlier. They read zero until DELAY steps have passed since reset.
- R9: Every intermediate result that is stored saturates to the range [−2^23, 2^23−1] and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance one timestep |
| i_syn | input | 24 | Summed synaptic current, signed Q7.16 |
| spike_o | output | 1 | Spike emitted on the latest step |
| refr_o | output | 1 | Neuron is refractory for the next step |
| v_o | output | 24 | Membrane potential, signed Q7.16 |
| thr_o | output | 24 | Present firing threshold, signed Q7.16 |
| spike_dly_o | output | 1 | Spike delayed by DELAY steps |
| v_dly_o | output | 24 | Potential delayed by DELAY steps |

## Verification
The bench builds two copies side by side, one adaptive and one plain. Both use ALPHA_SHIFT=3, RHO_SHIFT=4, BETA_SHL=1, ADAPT_INC=0.25, VTHR=1.0, REFR_STEPS=5 and DELAY=3. With leak and adaptation shifts this short, both the potential and the threshold settle within a few dozen steps. Sweeps over held current levels and pseudo-random currents therefore reach repeated firing, refractory blocking and accumulated threshold growth. A three-stage chain is deep enough to exercise the delay alignment. Currents at full scale, positive and negative, drive the sum into both saturation limits.

// File: rtl/alif_pkg.sv
package alif_pkg;
    localparam int unsigned FX_W     = 24;
    localparam int unsigned FX_FRAC  = 16;
    localparam int unsigned FX_GUARD = 4;
    localparam int unsigned WIDE_W   = FX_W + FX_GUARD;

    typedef logic signed [FX_W-1:0]   fx_t;
    typedef logic signed [WIDE_W-1:0] fx_wide_t;

    localparam fx_wide_t FX_MAX_W = fx_wide_t'((64'sd1 <<< (FX_W - 1)) - 64'sd1);
    localparam fx_wide_t FX_MIN_W = fx_wide_t'(-(64'sd1 <<< (FX_W - 1)));

    typedef enum logic [0:0] {
        ST_INTEGRATE = 1'b0,
        ST_REFRACT   = 1'b1
    } refr_state_e;

    function automatic fx_wide_t fx_widen(input fx_t x);
        return fx_wide_t'(x);
    endfunction

    function automatic fx_t fx_sat(input fx_wide_t x);
        if (x > FX_MAX_W) begin
            return fx_t'(FX_MAX_W);
        end else if (x < FX_MIN_W) begin
            return fx_t'(FX_MIN_W);
        end
        return fx_t'(x);
    endfunction
endpackage

// File: rtl/alif_refractory_fsm.sv
module alif_refractory_fsm
    import alif_pkg::*;
#(
    parameter int unsigned REFR_STEPS = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic step_en,
    input  logic fire_i,
    output logic refractory_o
);
    localparam int unsigned CNT_W = $clog2(REFR_STEPS) + 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(REFR_STEPS - 1);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    refr_state_e      state_q, state_d;
    logic [CNT_W-1:0] left_q, left_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_INTEGRATE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            ST_INTEGRATE: begin
                if (step_en && fire_i && (REFR_STEPS > 1)) begin
                    state_d = ST_REFRACT;
                    left_d  = LAST_CNT;
                end
            end
            ST_REFRACT: begin
                if (step_en) begin
                    if (left_q == ONE_CNT) begin
                        state_d = ST_INTEGRATE;
                        left_d  = '0;
                    end else begin
                        left_d = left_q - ONE_CNT;
                    end
                end
            end
            default: begin
                state_d = ST_INTEGRATE;
                left_d  = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        refractory_o = (state_q == ST_REFRACT);
    end
endmodule

// File: rtl/alif_threshold.sv
module alif_threshold
    import alif_pkg::*;
#(
    parameter bit          ADAPTIVE  = 1'b1,
    parameter int unsigned RHO_SHIFT = 6,
    parameter int unsigned BETA_SHL  = 1,
    parameter int          ADAPT_INC = 32768,
    parameter int          VTHR      = 65536
) (
    input  logic clk,
    input  logic rst,
    input  logic step_en,
    input  logic fire_i,
    output fx_t  thr_o
);
    localparam fx_wide_t VTHR_W = fx_wide_t'(VTHR);
    localparam fx_wide_t INC_W  = fx_wide_t'(ADAPT_INC);

    if (ADAPTIVE) begin : g_adaptive
        fx_t      a_q;
        fx_wide_t a_w;
        fx_t      a_next;

        always_comb begin
            a_w    = fx_widen(a_q);
            a_next = fx_sat(a_w - (a_w >>> RHO_SHIFT) + (fire_i ? INC_W : '0));
            thr_o  = fx_sat(VTHR_W + (a_w <<< BETA_SHL));
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                a_q <= '0;
            end else if (step_en) begin
                a_q <= a_next;
            end
        end
    end else begin : g_fixed
        logic unused_fixed;
        assign unused_fixed = ^{clk, rst, step_en, fire_i};
        assign thr_o        = fx_sat(VTHR_W);
    end
endmodule

// File: rtl/alif_membrane.sv
module alif_membrane
    import alif_pkg::*;
#(
    parameter int unsigned ALPHA_SHIFT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic step_en,
    input  fx_t  i_syn,
    input  logic refractory_i,
    input  fx_t  thr_i,
    output logic fire_o,
    output fx_t  v_o
);
    fx_t      v_q;
    fx_wide_t v_w;
    fx_wide_t decay_w;
    fx_wide_t integ_w;
    fx_t      sum_sat;
    fx_t      v_next;

    always_comb begin
        v_w     = fx_widen(v_q);
        decay_w = v_w - (v_w >>> ALPHA_SHIFT);
        integ_w = refractory_i ? '0 : fx_widen(i_syn);
        sum_sat = fx_sat(decay_w + integ_w);
        fire_o  = !refractory_i && (sum_sat >= thr_i);
        v_next  = fire_o ? fx_sat(fx_widen(sum_sat) - fx_widen(thr_i)) : sum_sat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= '0;
        end else if (step_en) begin
            v_q <= v_next;
        end
    end

    assign v_o = v_q;
endmodule

// File: rtl/alif_delay_line.sv
module alif_delay_line #(
    parameter int unsigned W     = 24,
    parameter int unsigned DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_en,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [DEPTH-1:0][W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else if (step_en) begin
            stage_q[0] <= d_i;
            for (int s = 1; s < DEPTH; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/alif_neuron.sv
module alif_neuron
    import alif_pkg::*;
#(
    parameter bit          ADAPTIVE    = 1'b1,
    parameter int unsigned ALPHA_SHIFT = 4,
    parameter int unsigned RHO_SHIFT   = 6,
    parameter int unsigned BETA_SHL    = 1,
    parameter int          ADAPT_INC   = 32768,
    parameter int          VTHR        = 65536,
    parameter int unsigned REFR_STEPS  = 5,
    parameter int unsigned DELAY       = 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   step_en,
    input  logic signed [FX_W-1:0] i_syn,
    output logic                   spike_o,
    output logic                   refr_o,
    output logic signed [FX_W-1:0] v_o,
    output logic signed [FX_W-1:0] thr_o,
    output logic                   spike_dly_o,
    output logic signed [FX_W-1:0] v_dly_o
);
    logic fire;
    logic refractory;
    fx_t  thr;
    fx_t  v_cur;
    logic spike_q;

    alif_refractory_fsm #(
        .REFR_STEPS(REFR_STEPS)
    ) u_refr (
        .clk         (clk),
        .rst         (rst),
        .step_en     (step_en),
        .fire_i      (fire),
        .refractory_o(refractory)
    );

    alif_threshold #(
        .ADAPTIVE (ADAPTIVE),
        .RHO_SHIFT(RHO_SHIFT),
        .BETA_SHL (BETA_SHL),
        .ADAPT_INC(ADAPT_INC),
        .VTHR     (VTHR)
    ) u_thr (
        .clk    (clk),
        .rst    (rst),
        .step_en(step_en),
        .fire_i (fire),
        .thr_o  (thr)
    );

    alif_membrane #(
        .ALPHA_SHIFT(ALPHA_SHIFT)
    ) u_mem (
        .clk         (clk),
        .rst         (rst),
        .step_en     (step_en),
        .i_syn       (i_syn),
        .refractory_i(refractory),
        .thr_i       (thr),
        .fire_o      (fire),
        .v_o         (v_cur)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            spike_q <= 1'b0;
        end else if (step_en) begin
            spike_q <= fire;
        end
    end

    alif_delay_line #(
        .W    (1),
        .DEPTH(DELAY)
    ) u_spike_dly (
        .clk    (clk),
        .rst    (rst),
        .step_en(step_en),
        .d_i    (spike_q),
        .q_o    (spike_dly_o)
    );

    alif_delay_line #(
        .W    (FX_W),
        .DEPTH(DELAY)
    ) u_v_dly (
        .clk    (clk),
        .rst    (rst),
        .step_en(step_en),
        .d_i    (v_cur),
        .q_o    (v_dly_o)
    );

    assign spike_o = spike_q;
    assign refr_o  = refractory;
    assign v_o     = v_cur;
    assign thr_o   = thr;
endmodule

// File: rtl/alif_neuron_chk.sv
module alif_neuron_chk
    import alif_pkg::*;
#(
    parameter bit          ADAPTIVE   = 1'b1,
    parameter int          VTHR       = 65536,
    parameter int unsigned REFR_STEPS = 5
) (
    input logic clk,
    input logic rst,
    input logic step_en,
    input logic spike_o,
    input logic refr_o,
    input fx_t  v_o,
    input fx_t  thr_o,
    input logic spike_dly_o,
    input fx_t  v_dly_o
);
    localparam fx_t VTHR_FX = fx_t'(VTHR);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (v_o == '0 && !spike_o && !refr_o && !spike_dly_o && v_dly_o == '0));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> ($stable(v_o) && $stable(spike_o) && $stable(thr_o) && $stable(refr_o)));

    a_r5_silent_refract: assert property (@(posedge clk) disable iff (rst)
        (refr_o && step_en) |=> !spike_o);

    a_r6_thr_floor: assert property (@(posedge clk) disable iff (rst)
        thr_o >= VTHR_FX);

    if (REFR_STEPS > 1) begin : g_refr
        a_r4_spike_enters_refract: assert property (@(posedge clk) disable iff (rst)
            spike_o |-> refr_o);
    end

    if (!ADAPTIVE) begin : g_fixed
        a_r7_fixed_thr: assert property (@(posedge clk) disable iff (rst)
            thr_o == VTHR_FX);
    end
endmodule

bind alif_neuron alif_neuron_chk #(
    .ADAPTIVE  (ADAPTIVE),
    .VTHR      (VTHR),
    .REFR_STEPS(REFR_STEPS)
) u_alif_neuron_chk (
    .clk        (clk),
    .rst        (rst),
    .step_en    (step_en),
    .spike_o    (spike_o),
    .refr_o     (refr_o),
    .v_o        (v_o),
    .thr_o      (thr_o),
    .spike_dly_o(spike_dly_o),
    .v_dly_o    (v_dly_o)
);

// File: tb/test_alif_neuron.sv
module test_alif_neuron;
    localparam int  ALPHA_SHIFT = 3;
    localparam int  RHO_SHIFT   = 4;
    localparam int  BETA_SHL    = 1;
    localparam int  ADAPT_INC   = 16384;
    localparam int  VTHR        = 65536;
    localparam int  REFR_STEPS  = 5;
    localparam int  DELAY       = 3;
    localparam longint SMAX     = 64'sd8388607;
    localparam longint SMIN     = -64'sd8388608;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step_en = 1'b0;
    logic signed [23:0] i_syn = '0;

    logic               spk[2], refr[2], sdly[2];
    logic signed [23:0] vo[2], thro[2], vdly[2];

    always #10 clk = ~clk;

    alif_neuron #(
        .ADAPTIVE(1'b1), .ALPHA_SHIFT(ALPHA_SHIFT), .RHO_SHIFT(RHO_SHIFT),
        .BETA_SHL(BETA_SHL), .ADAPT_INC(ADAPT_INC), .VTHR(VTHR),
        .REFR_STEPS(REFR_STEPS), .DELAY(DELAY)
    ) i_alif_neuron (
        .clk(clk), .rst(rst), .step_en(step_en), .i_syn(i_syn),
        .spike_o(spk[0]), .refr_o(refr[0]), .v_o(vo[0]), .thr_o(thro[0]),
        .spike_dly_o(sdly[0]), .v_dly_o(vdly[0])
    );

    alif_neuron #(
        .ADAPTIVE(1'b0), .ALPHA_SHIFT(ALPHA_SHIFT), .RHO_SHIFT(RHO_SHIFT),
        .BETA_SHL(BETA_SHL), .ADAPT_INC(ADAPT_INC), .VTHR(VTHR),
        .REFR_STEPS(REFR_STEPS), .DELAY(DELAY)
    ) i_alif_neuron_lif (
        .clk(clk), .rst(rst), .step_en(step_en), .i_syn(i_syn),
        .spike_o(spk[1]), .refr_o(refr[1]), .v_o(vo[1]), .thr_o(thro[1]),
        .spike_dly_o(sdly[1]), .v_dly_o(vdly[1])
    );

    int vectors = 0;
    int miscompares = 0;

    longint m_v[2], m_a[2], m_dv[2][DELAY];
    int     m_cnt[2];
    bit     m_spk[2], m_ds[2][DELAY], m_sat[2];

    function automatic longint sat(input longint x);
        if (x > SMAX) return SMAX;
        if (x < SMIN) return SMIN;
        return x;
    endfunction

    function automatic longint thr_of(input int k);
        if (k == 1) return VTHR;
        return sat(VTHR + (m_a[k] <<< BETA_SHL));
    endfunction

    task automatic model_reset(input int k);
        m_v[k] = 0; m_a[k] = 0; m_cnt[k] = 0; m_spk[k] = 0; m_sat[k] = 0;
        for (int j = 0; j < DELAY; j++) begin
            m_dv[k][j] = 0;
            m_ds[k][j] = 0;
        end
    endtask

    task automatic model_step(input int k, input longint cur);
        longint thr, dec, raw, sum;
        bit refrac, fire;
        thr = thr_of(k);
        for (int j = DELAY - 1; j > 0; j--) begin
            m_dv[k][j] = m_dv[k][j-1];
            m_ds[k][j] = m_ds[k][j-1];
        end
        m_dv[k][0] = m_v[k];
        m_ds[k][0] = m_spk[k];
        refrac = (m_cnt[k] > 0);
        dec = m_v[k] - (m_v[k] >>> ALPHA_SHIFT);
        raw = dec + (refrac ? 64'sd0 : cur);
        sum = sat(raw);
        m_sat[k] = (sum != raw);
        fire = !refrac && (sum >= thr);
        m_v[k] = fire ? sat(sum - thr) : sum;
        if (k == 0) m_a[k] = sat(m_a[k] - (m_a[k] >>> RHO_SHIFT) + (fire ? ADAPT_INC : 0));
        else        m_a[k] = 0;
        if (refrac)    m_cnt[k] = m_cnt[k] - 1;
        else if (fire) m_cnt[k] = REFR_STEPS - 1;
        m_spk[k] = fire;
    endtask

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic apply(input bit r, input bit en, input longint cur);
        longint av;
        string tag;
        @(negedge clk);
        rst = r;
        step_en = en;
        i_syn = cur[23:0];
        @(posedge clk);
        #1;
        for (int k = 0; k < 2; k++) begin
            if (r) model_reset(k);
            else if (en) model_step(k, cur);
        end
        for (int k = 0; k < 2; k++) begin
            av = vo[k];
            if (r) tag = "R1";
            else if (!en) tag = "R2";
            else if (m_sat[k]) tag = "R9";
            else tag = "R3";
            chk(tag, k == 0 ? "v adaptive" : "v plain", av, m_v[k]);
            chk(r ? "R1" : (en ? "R4" : "R2"), "spike", spk[k], m_spk[k]);
            chk(r ? "R1" : (en ? "R5" : "R2"), "refractory", refr[k], m_cnt[k] > 0);
            av = thro[k];
            chk(r ? "R1" : (k == 0 ? "R6" : "R7"), "threshold", av, thr_of(k));
            chk(r ? "R1" : "R8", "delayed spike", sdly[k], m_ds[k][DELAY-1]);
            av = vdly[k];
            chk(r ? "R1" : "R8", "delayed v", av, m_dv[k][DELAY-1]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL R2 watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        longint levels[10];
        logic [23:0] lfsr;
        int cyc;
        levels = '{0, 4096, 16384, 32768, 65536, 98304, 262144, -32768, 12000, 150000};

        // R1: reset state
        apply(1'b1, 1'b0, 0);
        apply(1'b1, 1'b0, 0);

        // R3 R4 R5 R6 R7 R8: held current levels with idle cycles for R2
        cyc = 0;
        foreach (levels[li]) begin
            for (int n = 0; n < 60; n++) begin
                cyc++;
                apply(1'b0, (cyc % 7) != 3, levels[li]);
            end
        end

        // R9: positive and negative saturation
        for (int n = 0; n < 20; n++) apply(1'b0, 1'b1, SMAX);
        for (int n = 0; n < 20; n++) apply(1'b0, 1'b1, SMIN);
        for (int n = 0; n < 30; n++) apply(1'b0, 1'b1, SMAX);

        // R1 mid-run reset
        apply(1'b1, 1'b1, 65536);
        apply(1'b0, 1'b0, 65536);

        // pseudo-random currents
        lfsr = 24'hACE1F3;
        for (int n = 0; n < 1500; n++) begin
            longint c;
            lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
            c = longint'($signed(lfsr)) >>> (4 + lfsr[2:0]);
            apply(1'b0, lfsr[5:3] != 3'd0, c);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule